// File: doc/BRIEF.md
# DMA Address Range Guard

This block sits beside the translation pipeline of an I/O memory management unit. It decides whether each inbound DMA address is in range. A 16-bit control word holds three limits. Two are guest-address limits, one for isochronous engines and one for non-isochronous engines. The third is a host-address limit that both engine classes share. Software reads and writes the word through a one-cycle write port and a combinational read port. A sticky lock bit and a secure-mode input both freeze the limit fields.

Each request carries an address, an engine class, an address kind and a page-walk flag. The block returns one of three verdicts:

- pass;
- abort with an Unsupported Request completion;
- abort with no completion.

Guest-domain addresses are checked against the guest limit of their class. Translated and pass-through addresses skip that check and are held to the host limit. Host addresses fetched by the page walker are also held to the host limit. Building the completion is left to the surrounding logic.

Top module: `dma_limit_guard`

## Requirements
- R1: After reset the control word reads 16'h0708: lock bit 15 = 0, isochronous guest code in bits 10:8 = 3'b111, host code in bits 7:4 = 4'h0, non-isochronous guest code in bits 3:0 = 4'h8.
- R2: Bits 14:11 of the control word always read zero, whatever was written to them.
- R3: A write with bit 15 = 1 sets the lock. The lock stays set until reset. The locking write itself still updates bits 10:0. While the lock is set, every later write leaves bits 10:0 unchanged.
- R4: While `secure_mode` is high, writes leave bits 10:0 unchanged. The lock bit can still be set.
- R5: An isochronous guest access (kind 2'b00, no page walk, translation on) is aborted with verdict 2'b01 (Unsupported Request) when its address is at or above 2^(32+code), for codes 3'b100 to 3'b111. Otherwise it passes (verdict 2'b00).
- R6: A non-isochronous guest access is aborted with 2'b01 when its address is at or above 2^(40+code), for codes 4'h0 to 4'h8. Otherwise it passes.
- R7: If the guest code of a class is reserved, every guest access of that class is aborted with 2'b01, even address 0. Reserved codes are 3'b000 to 3'b011 for isochronous and 4'h9 to 4'hF for non-isochronous.
- R8: Translated (2'b01) and pass-through (2'b10, and also 2'b11) accesses ignore the guest limits. They are aborted with verdict 2'b10 (no completion) when the address is at or above 2^(36+host code). Otherwise they pass.
- R9: A request with the page-walk flag set is checked against the host limit only, whatever its kind. It is aborted with 2'b10 when it exceeds that limit.
- R10: With translation disabled, every request passes.
- R11: The verdict appears on `resp_valid` in the cycle after the request is accepted. `req_ready` is high whenever the output slot is empty or being drained. A stalled verdict holds its value until `resp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data |
| secure_mode | input | 1 | Freezes the limit fields while high |
| xlate_en | input | 1 | Translation enabled |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request address |
| req_isoch | input | 1 | 1 = isochronous engine class |
| req_kind | input | 2 | 00 guest, 01 translated, 10/11 pass-through |
| req_walk | input | 1 | Address issued by the page walker |
| resp_valid | output | 1 | Verdict present |
| resp_ready | input | 1 | Verdict consumer ready |
| resp_verdict | output | 2 | 00 pass, 01 abort with UR, 10 abort without completion |

## Verification
The bench probes each limit one below and exactly at its power of two. A design that compared with "greater than" instead of "at or above" would let the boundary address through. It loads reserved guest codes and checks that address 0 is still refused; a design that decoded the code arithmetically would pass it. It sends translated and walk requests with huge guest-illegal addresses that fit the host limit, which catches a design that applies the guest check to them or reports the wrong abort kind. It also holds the output stalled while a second request waits, and it writes under lock and under secure mode, which exposes any lost verdict or any limit field that still moves.

// File: rtl/dlg_pkg.sv
package dlg_pkg;

  typedef enum logic [1:0] {
    AK_GUEST    = 2'b00,
    AK_XLATED   = 2'b01,
    AK_PASSTHRU = 2'b10,
    AK_HOSTRSV  = 2'b11
  } addr_kind_e;

  typedef enum logic [1:0] {
    VD_PASS     = 2'b00,
    VD_ABORT_UR = 2'b01,
    VD_ABORT_NC = 2'b10
  } verdict_e;

  // order matches control word bits 10:0
  typedef struct packed {
    logic [2:0] iso_code;
    logic [3:0] host_code;
    logic [3:0] niso_code;
  } limits_t;

  localparam int unsigned ISO_BASE  = 32;
  localparam int unsigned NISO_BASE = 40;
  localparam int unsigned HOST_BASE = 36;
  localparam logic [3:0]  NISO_TOP  = 4'h8;

  function automatic logic iso_code_ok(logic [2:0] c);
    return c[2];
  endfunction

  function automatic logic niso_code_ok(logic [3:0] c);
    return c <= NISO_TOP;
  endfunction

  function automatic int unsigned iso_width(logic [2:0] c);
    return ISO_BASE + int'(c);
  endfunction

  function automatic int unsigned niso_width(logic [3:0] c);
    return NISO_BASE + int'(c);
  endfunction

  function automatic int unsigned host_width(logic [3:0] c);
    return HOST_BASE + int'(c);
  endfunction

  // true when any address bit at position w or above is set
  function automatic logic at_or_above(logic [63:0] a, int unsigned w);
    if (w >= 64) return 1'b0;
    return (a >> w) != 64'd0;
  endfunction

endpackage

// File: rtl/dlg_cfg_regs.sv
module dlg_cfg_regs
  import dlg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  input  logic        secure_mode,
  output logic [15:0] cfg_rdata,
  output limits_t     lim,
  output logic        lock_q
);
  localparam limits_t LIM_RST = '{iso_code: 3'b111, host_code: 4'h0, niso_code: 4'h8};
  localparam int unsigned LOCK_BIT = 15;

  logic field_wr_en;
  logic lock_set;

  assign field_wr_en = cfg_we && !lock_q && !secure_mode;
  assign lock_set    = cfg_we && cfg_wdata[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim    <= LIM_RST;
      lock_q <= 1'b0;
    end else begin
      if (field_wr_en) lim <= limits_t'(cfg_wdata[10:0]);
      if (lock_set) lock_q <= 1'b1;
    end
  end

  assign cfg_rdata = {lock_q, 4'b0000, lim};

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(lim));

  assert_secure_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    secure_mode |=> $stable(lim));

endmodule

// File: rtl/dlg_verdict_logic.sv
module dlg_verdict_logic
  import dlg_pkg::*;
(
  input  logic [63:0] addr,
  input  logic        isoch,
  input  addr_kind_e  kind,
  input  logic        walk,
  input  logic        xlate_en,
  input  limits_t     lim,
  output verdict_e    verdict
);
  logic guest_path;
  logic host_path;
  logic guest_code_ok;
  logic guest_over;
  logic host_over;

  assign host_path  = xlate_en && (walk || kind != AK_GUEST);
  assign guest_path = xlate_en && !walk && kind == AK_GUEST;

  always_comb begin
    if (isoch) begin
      guest_code_ok = iso_code_ok(lim.iso_code);
      guest_over    = at_or_above(addr, iso_width(lim.iso_code));
    end else begin
      guest_code_ok = niso_code_ok(lim.niso_code);
      guest_over    = at_or_above(addr, niso_width(lim.niso_code));
    end
  end

  assign host_over = at_or_above(addr, host_width(lim.host_code));

  always_comb begin
    verdict = VD_PASS;
    if (guest_path && (!guest_code_ok || guest_over)) verdict = VD_ABORT_UR;
    else if (host_path && host_over)                  verdict = VD_ABORT_NC;
  end

  always_comb begin
    assert_paths_exclusive_R8: assert (!(guest_path && host_path));
  end

endmodule

// File: rtl/dlg_resp_slot.sv
module dlg_resp_slot
  import dlg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  output logic     req_ready,
  input  verdict_e verdict_in,
  output logic     resp_valid,
  input  logic     resp_ready,
  output verdict_e resp_verdict
);
  logic accept;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_verdict <= VD_PASS;
    end else if (accept) begin
      resp_valid   <= 1'b1;
      resp_verdict <= verdict_in;
    end else if (resp_ready) begin
      resp_valid   <= 1'b0;
    end
  end

  assert_accept_yields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_verdict)));

endmodule

// File: rtl/dma_limit_guard.sv
module dma_limit_guard
  import dlg_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              secure_mode,
  input  logic              xlate_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_isoch,
  input  logic [1:0]        req_kind,
  input  logic              req_walk,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [1:0]        resp_verdict
);
  limits_t     lim;
  logic        lock_q;
  logic [63:0] addr_x;
  verdict_e    verdict_now;
  verdict_e    verdict_q;

  assign addr_x = 64'(req_addr);

  dlg_cfg_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_wdata, .secure_mode,
    .cfg_rdata, .lim, .lock_q
  );

  dlg_verdict_logic u_judge (
    .addr(addr_x), .isoch(req_isoch), .kind(addr_kind_e'(req_kind)),
    .walk(req_walk), .xlate_en, .lim, .verdict(verdict_now)
  );

  dlg_resp_slot u_slot (
    .clk, .rst_n, .req_valid, .req_ready, .verdict_in(verdict_now),
    .resp_valid, .resp_ready, .resp_verdict(verdict_q)
  );

  assign resp_verdict = verdict_q;

  assert_off_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlate_en) |=> resp_verdict == 2'b00);

  assert_guest_never_nc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'b00 && !req_walk) |=> resp_verdict != 2'b10);

  assert_host_never_ur_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_walk || req_kind != 2'b00)) |=> resp_verdict != 2'b01);

endmodule

// File: tb/dma_limit_guard_tb.sv
module dma_limit_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        secure_mode = 1'b0;
  logic        xlate_en = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_isoch = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        req_walk = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [1:0]  resp_verdict;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;
  logic [15:0] m_reg;

  always #5 clk = ~clk;

  dma_limit_guard #(.ADDR_W(64)) u_dut (.*);

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] model_write(logic [15:0] cur, logic [15:0] w, logic sec);
    logic [15:0] n = cur;
    if (!cur[15] && !sec) n[10:0] = w[10:0];
    if (w[15]) n[15] = 1'b1;
    n[14:11] = 4'b0;
    return n;
  endfunction

  function automatic logic beyond(logic [63:0] a, int e);
    if (e >= 64) return 1'b0;
    return a >= (64'd1 << e);
  endfunction

  function automatic logic [1:0] model_verdict(logic [15:0] r, logic [63:0] a,
                                                logic iso, logic [1:0] k, logic wk, logic xe);
    if (!xe) return 2'b00;
    if (wk || k != 2'b00) return beyond(a, 36 + int'(r[7:4])) ? 2'b10 : 2'b00;
    if (iso) begin
      if (r[10:8] < 3'd4) return 2'b01;
      return beyond(a, 32 + int'(r[10:8])) ? 2'b01 : 2'b00;
    end
    if (r[3:0] > 4'd8) return 2'b01;
    return beyond(a, 40 + int'(r[3:0])) ? 2'b01 : 2'b00;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    m_reg = 16'h0708;
  endtask

  task automatic wr(string req, logic [15:0] w, logic sec);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w; secure_mode = sec;
    @(negedge clk);
    cfg_we = 1'b0; secure_mode = 1'b0;
    m_reg = model_write(m_reg, w, sec);
    chk(req, cfg_rdata, m_reg);
  endtask

  task automatic rq(string req, logic [63:0] a, logic iso, logic [1:0] k, logic wk, logic xe);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_isoch = iso; req_kind = k; req_walk = wk; xlate_en = xe;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 16'(resp_valid), 16'd1);
    chk(req, 16'(resp_verdict), 16'(model_verdict(m_reg, a, iso, k, wk, xe)));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7564));
    do_reset();
    chk("R1 reset word", cfg_rdata, 16'h0708);
    chk("R11 idle ready", 16'(req_ready), 16'd1);

    // defaults: niso 2^48, iso 2^39, host 2^36
    rq("R6 niso below", (64'd1 << 48) - 1, 1'b0, 2'b00, 1'b0, 1'b1);
    rq("R6 niso at",    64'd1 << 48,       1'b0, 2'b00, 1'b0, 1'b1);
    rq("R5 iso below",  (64'd1 << 39) - 1, 1'b1, 2'b00, 1'b0, 1'b1);
    rq("R5 iso at",     64'd1 << 39,       1'b1, 2'b00, 1'b0, 1'b1);
    rq("R8 xlated below", (64'd1 << 36) - 1, 1'b0, 2'b01, 1'b0, 1'b1);
    rq("R8 xlated at",    64'd1 << 36,       1'b1, 2'b01, 1'b0, 1'b1);
    rq("R8 passthru at",  64'd1 << 36,       1'b0, 2'b10, 1'b0, 1'b1);
    rq("R9 walk guest-kind", 64'd1 << 36,    1'b0, 2'b00, 1'b1, 1'b1);
    rq("R10 off huge", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'b00, 1'b0, 1'b0);
    rq("R10 off walk", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 1'b1, 1'b0);

    // host code F gives 2^51; guest-illegal address fits host limit
    wr("R2 reserved bits", 16'h7FF9, 1'b0);
    rq("R7 niso reserved addr0", 64'd0, 1'b0, 2'b00, 1'b0, 1'b1);
    rq("R8 xlated skips guest", (64'd1 << 51) - 1, 1'b0, 2'b01, 1'b0, 1'b1);
    rq("R8 host at 2^51", 64'd1 << 51, 1'b0, 2'b11, 1'b0, 1'b1);
    wr("R7 iso reserved load", 16'h0300, 1'b0);
    rq("R7 iso reserved addr0", 64'd0, 1'b1, 2'b00, 1'b0, 1'b1);
    rq("R7 iso reserved xlated", 64'd0, 1'b1, 2'b01, 1'b0, 1'b1);
    rq("R6 niso code0 at", 64'd1 << 40, 1'b0, 2'b00, 1'b0, 1'b1);
    rq("R6 niso code0 below", (64'd1 << 40) - 1, 1'b0, 2'b00, 1'b0, 1'b1);

    // secure mode
    wr("R4 secure blocks", 16'h0555, 1'b1);
    chk("R4 secure unchanged", cfg_rdata, 16'h0300);

    // stall behaviour
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_addr = 64'd0; req_isoch = 1'b1; req_kind = 2'b00; req_walk = 1'b0; xlate_en = 1'b1;
    @(negedge clk);
    chk("R11 first verdict", 16'(resp_verdict), 16'h1);
    chk("R11 ready low", 16'(req_ready), 16'd0);
    req_isoch = 1'b0; req_addr = 64'd5;
    @(negedge clk);
    chk("R11 held", 16'(resp_verdict), 16'h1);
    chk("R11 still valid", 16'(resp_valid), 16'd1);
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 second verdict", 16'(resp_verdict), 16'h0);
    @(negedge clk);
    chk("R11 drained", 16'(resp_valid), 16'd0);

    // random phase, unlocked
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 4) == 0) begin
        wr("R3 random write", 16'($urandom) & 16'h7FFF, $urandom_range(0, 9) == 0);
      end else begin
        logic [63:0] a;
        int w;
        w = $urandom_range(30, 60);
        a = {$urandom, $urandom} >> (64 - w);
        rq("R5 random req", a, 1'($urandom), 2'($urandom), $urandom_range(0, 5) == 0,
           $urandom_range(0, 9) != 0);
      end
    end

    // lock
    do_reset();
    wr("R4 lock under secure", 16'h8000, 1'b1);
    chk("R4 lock set fields kept", cfg_rdata, 16'h8708);
    wr("R3 locked write ignored", 16'h0123, 1'b0);
    do_reset();
    chk("R3 reset clears lock", cfg_rdata, 16'h0708);
    wr("R3 locking write", 16'h8123, 1'b0);
    chk("R3 locked value", cfg_rdata, 16'h8123);
    wr("R3 write after lock", 16'h0456, 1'b0);
    chk("R3 unchanged", cfg_rdata, 16'h8123);
    rq("R5 iso code1 reserved", 64'd0, 1'b1, 2'b00, 1'b0, 1'b1);
    rq("R8 host code2 at", 64'd1 << 38, 1'b0, 2'b01, 1'b0, 1'b1);
    rq("R6 niso code3 below", (64'd1 << 43) - 1, 1'b0, 2'b00, 1'b0, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule